// File: doc/BRIEF.md
# Wormhole IP-over-ATM Cell Filter

This block sits on an ATM link at the edge of a network and looks at one cell per clock. Every cell is classified through a connection table addressed by the low bits of its incoming VPI and VCI. Cells on native ATM connections leave with the VPI/VCI pair held in the table. Cells on connections marked as IP traffic are steered packet by packet. The first cell of an IP packet picks an output VP from a small routing table keyed by the top byte of the IPv4 destination address. It then takes a VC identifier from that VP's free list and stores the pair as a temporary connection. Following cells reuse the stored pair. The end-of-packet cell closes the connection and hands the VC back, so per-packet paths exist without any signalling.

The routing table and the connection table are written through two plain configuration ports. The free lists fill themselves at reset. A forwarded cell appears at the output one clock after it was presented, with its PTI and payload unchanged.

Top module: `wipf_cell_filter`

## Requirements
- R1: After reset `out_valid` is 0, every connection entry has kind none, and each VP's free list holds FL_DEPTH identifiers that are handed out in the order VC_BASE, VC_BASE+1, and so on upward.
- R2: A cell whose entry has kind native (kind code 1) is forwarded with the entry's output VPI and VCI. Its PTI and payload are unchanged.
- R3: A cell whose entry has kind none (code 0) is dropped. The entry is addressed as {VPI low VPI_IDX_W bits, VCI low VCI_IDX_W bits}.
- R4: On an IP entry (code 2) with no open connection, a user cell is a first cell. The routing key is payload byte DST_BYTE, where byte k occupies bits 8k+7..8k. The cell leaves with VPI = IP_VPI_BASE + routed VP and with VCI = the head of that VP's free list, which is removed.
- R5: Further user cells on an open IP connection are forwarded with the stored VPI/VCI and do not change the state.
- R6: A user cell with PTI bit 0 set (PTI[2]=0, PTI[0]=1) is end of packet. On an open connection it is forwarded, the connection closes, and its VC goes to the tail of its VP's free list in the same clock. The next user cell is again a first cell.
- R7: A first cell that is also end of packet is forwarded with the head VC of its VP, and the VC is not removed from the free list.
- R8: A first cell that finds its VP's free list empty is dropped. If it is not end of packet, every later user cell of that connection is dropped up to and including the end-of-packet cell. After that, the next cell is a first cell again.
- R9: A cell with PTI[2]=1 on an IP entry is dropped and leaves the connection state unchanged.
- R10: Output follows input by exactly one clock. `out_valid` is 0 in any clock after a cycle without an accepted cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A cell is presented this cycle |
| in_vpi | input | VPI_W | Incoming VPI |
| in_vci | input | VCI_W | Incoming VCI |
| in_pti | input | 3 | Incoming PTI |
| in_pay | input | 8*PAY_BYTES | Leading payload bytes, byte k at bits 8k+7..8k |
| cfg_conn_we | input | 1 | Write one connection entry |
| cfg_conn_idx | input | VPI_IDX_W+VCI_IDX_W | Entry index |
| cfg_conn_kind | input | 2 | 0 none, 1 native, 2 IP |
| cfg_conn_vpi | input | VPI_W | Output VPI for a native entry |
| cfg_conn_vci | input | VCI_W | Output VCI for a native entry |
| cfg_route_we | input | 1 | Write one routing entry |
| cfg_route_key | input | 8 | Destination top byte |
| cfg_route_vp | input | VP_AW | Output VP index for that key |
| out_valid | output | 1 | A forwarded cell is present |
| out_vpi | output | VPI_W | Translated VPI |
| out_vci | output | VCI_W | Translated VCI |
| out_pti | output | 3 | PTI carried through |
| out_pay | output | 8*PAY_BYTES | Payload carried through |

## Verification
The bench builds the filter with FL_DEPTH = 4, VC_BASE = 100 and IP_VPI_BASE = 40, keeping four output VPs. A shallow free list lets four concurrent packets drain one VP. This brings the empty-list drop, the drop-until-end-of-packet run and the reuse of a returned VC within a few dozen cells. Distinct base values make each translated VPI and VCI traceable to its VP and to its position in the FIFO order.

// File: rtl/wipf_pkg.sv
package wipf_pkg;

   typedef enum logic [1:0] {
      CK_NONE   = 2'd0,
      CK_NATIVE = 2'd1,
      CK_IP     = 2'd2
   } conn_kind_e;

   // user data cell carrying the end-of-packet mark
   function automatic logic pti_is_eop(input logic [2:0] pti);
      return (pti[2] == 1'b0) && (pti[0] == 1'b1);
   endfunction

   function automatic logic pti_is_user(input logic [2:0] pti);
      return pti[2] == 1'b0;
   endfunction

endpackage

// File: rtl/wipf_conn_table.sv
module wipf_conn_table
   import wipf_pkg::*;
#(
   parameter int IDX_W = 6,
   parameter int VPI_W = 8,
   parameter int VCI_W = 16,
   parameter int VP_AW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output conn_kind_e        rd_kind,
   output logic              rd_active,
   output logic              rd_drop,
   output logic [VP_AW-1:0]  rd_vp,
   output logic [VPI_W-1:0]  rd_vpi,
   output logic [VCI_W-1:0]  rd_vci,
   input  logic              upd_en,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic              upd_active,
   input  logic              upd_drop,
   input  logic [VP_AW-1:0]  upd_vp,
   input  logic [VPI_W-1:0]  upd_vpi,
   input  logic [VCI_W-1:0]  upd_vci,
   input  logic              cfg_en,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  conn_kind_e        cfg_kind,
   input  logic [VPI_W-1:0]  cfg_vpi,
   input  logic [VCI_W-1:0]  cfg_vci
);
   localparam int ENTRIES = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
         $error("wipf_conn_table: IDX_W out of range");
      end
   endgenerate

   conn_kind_e         kind_q [ENTRIES];
   logic               act_q  [ENTRIES];
   logic               drop_q [ENTRIES];
   logic [VP_AW-1:0]   vp_q   [ENTRIES];
   logic [VPI_W-1:0]   vpi_q  [ENTRIES];
   logic [VCI_W-1:0]   vci_q  [ENTRIES];

   assign rd_kind   = kind_q[rd_idx];
   assign rd_active = act_q[rd_idx];
   assign rd_drop   = drop_q[rd_idx];
   assign rd_vp     = vp_q[rd_idx];
   assign rd_vpi    = vpi_q[rd_idx];
   assign rd_vci    = vci_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            kind_q[e] <= CK_NONE;
            act_q[e]  <= 1'b0;
            drop_q[e] <= 1'b0;
            vp_q[e]   <= '0;
            vpi_q[e]  <= '0;
            vci_q[e]  <= '0;
         end
      end else begin
         if (upd_en) begin
            act_q[upd_idx]  <= upd_active;
            drop_q[upd_idx] <= upd_drop;
            vp_q[upd_idx]   <= upd_vp;
            vpi_q[upd_idx]  <= upd_vpi;
            vci_q[upd_idx]  <= upd_vci;
         end
         // a configuration write wins over a cell update to the same entry
         if (cfg_en) begin
            kind_q[cfg_idx] <= cfg_kind;
            act_q[cfg_idx]  <= 1'b0;
            drop_q[cfg_idx] <= 1'b0;
            vpi_q[cfg_idx]  <= cfg_vpi;
            vci_q[cfg_idx]  <= cfg_vci;
         end
      end
   end

   AST_UPD_OPEN_OR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |-> !(upd_active && upd_drop)); // R8

endmodule

// File: rtl/wipf_route_table.sv
module wipf_route_table #(
   parameter int KEY_W = 8,
   parameter int VP_AW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [KEY_W-1:0]  cfg_key,
   input  logic [VP_AW-1:0]  cfg_vp,
   input  logic [KEY_W-1:0]  key,
   output logic [VP_AW-1:0]  vp
);
   localparam int KEYS = 1 << KEY_W;

   generate
      if (KEY_W < 1 || KEY_W > 10) begin : g_bad_key
         $error("wipf_route_table: KEY_W out of range");
      end
   endgenerate

   logic [VP_AW-1:0] map_q [KEYS];

   assign vp = map_q[key];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < KEYS; k++) map_q[k] <= '0;
      end else if (cfg_we) begin
         map_q[cfg_key] <= cfg_vp;
      end
   end

endmodule

// File: rtl/wipf_vc_free_list.sv
module wipf_vc_free_list #(
   parameter int DEPTH   = 16,
   parameter int VCI_W   = 16,
   parameter int VC_BASE = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop,
   input  logic              push,
   input  logic [VCI_W-1:0]  push_vc,
   output logic [VCI_W-1:0]  head_vc,
   output logic              empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("wipf_vc_free_list: DEPTH must be at least 2");
      end
      if (VC_BASE + DEPTH > (1 << VCI_W)) begin : g_bad_base
         $error("wipf_vc_free_list: identifiers exceed VCI width");
      end
   endgenerate

   logic [VCI_W-1:0] mem_q [DEPTH];
   logic [AW-1:0]    rd_q, wr_q;
   logic [CW-1:0]    cnt_q;

   assign head_vc = mem_q[rd_q];
   assign empty   = (cnt_q == '0);

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= VCI_W'(VC_BASE + k);
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= CW'(DEPTH);
      end else begin
         if (push) begin
            mem_q[wr_q] <= push_vc;
            wr_q        <= nxt(wr_q);
         end
         if (pop) rd_q <= nxt(rd_q);
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_FL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < CW'(DEPTH))); // R6
   AST_FL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R4
   AST_FL_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && push)); // R7

endmodule

// File: rtl/wipf_cell_filter.sv
module wipf_cell_filter
   import wipf_pkg::*;
#(
   parameter int VPI_W       = 8,
   parameter int VCI_W       = 16,
   parameter int VPI_IDX_W   = 2,
   parameter int VCI_IDX_W   = 4,
   parameter int VP_AW       = 2,
   parameter int FL_DEPTH    = 16,
   parameter int VC_BASE     = 32,
   parameter int IP_VPI_BASE = 16,
   parameter int PAY_BYTES   = 24,
   parameter int DST_BYTE    = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [VPI_W-1:0]               in_vpi,
   input  logic [VCI_W-1:0]               in_vci,
   input  logic [2:0]                     in_pti,
   input  logic [8*PAY_BYTES-1:0]         in_pay,
   input  logic                           cfg_conn_we,
   input  logic [VPI_IDX_W+VCI_IDX_W-1:0] cfg_conn_idx,
   input  logic [1:0]                     cfg_conn_kind,
   input  logic [VPI_W-1:0]               cfg_conn_vpi,
   input  logic [VCI_W-1:0]               cfg_conn_vci,
   input  logic                           cfg_route_we,
   input  logic [7:0]                     cfg_route_key,
   input  logic [VP_AW-1:0]               cfg_route_vp,
   output logic                           out_valid,
   output logic [VPI_W-1:0]               out_vpi,
   output logic [VCI_W-1:0]               out_vci,
   output logic [2:0]                     out_pti,
   output logic [8*PAY_BYTES-1:0]         out_pay
);
   localparam int IDX_W  = VPI_IDX_W + VCI_IDX_W;
   localparam int NUM_VP = 1 << VP_AW;
   localparam int PAY_W  = 8 * PAY_BYTES;

   generate
      if (DST_BYTE >= PAY_BYTES) begin : g_bad_dst
         $error("wipf_cell_filter: DST_BYTE outside payload window");
      end
      if (VPI_IDX_W > VPI_W || VCI_IDX_W > VCI_W) begin : g_bad_idx
         $error("wipf_cell_filter: index wider than header field");
      end
      if (IP_VPI_BASE + NUM_VP > (1 << VPI_W)) begin : g_bad_vpi
         $error("wipf_cell_filter: IP VPIs exceed VPI width");
      end
   endgenerate

   // ---------------- lookups ----------------
   logic [IDX_W-1:0] idx;
   logic [7:0]       dst_key;
   logic [VP_AW-1:0] route_vp;

   assign idx     = {in_vpi[VPI_IDX_W-1:0], in_vci[VCI_IDX_W-1:0]};
   assign dst_key = in_pay[8*DST_BYTE +: 8];

   conn_kind_e       rd_kind;
   logic             rd_active, rd_drop;
   logic [VP_AW-1:0] rd_vp;
   logic [VPI_W-1:0] rd_vpi;
   logic [VCI_W-1:0] rd_vci;

   logic             upd_en, upd_active, upd_drop;
   logic [VP_AW-1:0] upd_vp;
   logic [VPI_W-1:0] upd_vpi;
   logic [VCI_W-1:0] upd_vci;

   wipf_conn_table #(
      .IDX_W (IDX_W),
      .VPI_W (VPI_W),
      .VCI_W (VCI_W),
      .VP_AW (VP_AW)
   ) i_conn (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (idx),
      .rd_kind    (rd_kind),
      .rd_active  (rd_active),
      .rd_drop    (rd_drop),
      .rd_vp      (rd_vp),
      .rd_vpi     (rd_vpi),
      .rd_vci     (rd_vci),
      .upd_en     (upd_en),
      .upd_idx    (idx),
      .upd_active (upd_active),
      .upd_drop   (upd_drop),
      .upd_vp     (upd_vp),
      .upd_vpi    (upd_vpi),
      .upd_vci    (upd_vci),
      .cfg_en     (cfg_conn_we),
      .cfg_idx    (cfg_conn_idx),
      .cfg_kind   (conn_kind_e'(cfg_conn_kind)),
      .cfg_vpi    (cfg_conn_vpi),
      .cfg_vci    (cfg_conn_vci)
   );

   wipf_route_table #(
      .KEY_W (8),
      .VP_AW (VP_AW)
   ) i_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_route_we),
      .cfg_key (cfg_route_key),
      .cfg_vp  (cfg_route_vp),
      .key     (dst_key),
      .vp      (route_vp)
   );

   // ---------------- free lists, one per output VP ----------------
   logic                fl_pop   [NUM_VP];
   logic                fl_push  [NUM_VP];
   logic [NUM_VP-1:0]   fl_empty;
   logic [VCI_W-1:0]    fl_head  [NUM_VP];
   logic                take_vc, give_vc;

   generate
      for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
         assign fl_pop[v]  = take_vc && (route_vp == VP_AW'(v));
         assign fl_push[v] = give_vc && (rd_vp == VP_AW'(v));
         wipf_vc_free_list #(
            .DEPTH   (FL_DEPTH),
            .VCI_W   (VCI_W),
            .VC_BASE (VC_BASE)
         ) i_fl (
            .clk     (clk),
            .rst_n   (rst_n),
            .pop     (fl_pop[v]),
            .push    (fl_push[v]),
            .push_vc (rd_vci),
            .head_vc (fl_head[v]),
            .empty   (fl_empty[v])
         );
      end
   endgenerate

   // ---------------- per-cell decision ----------------
   logic             fwd;
   logic [VPI_W-1:0] nxt_vpi;
   logic [VCI_W-1:0] nxt_vci;
   logic             eop, user;
   logic [VPI_W-1:0] ip_vpi;

   assign eop    = pti_is_eop(in_pti);
   assign user   = pti_is_user(in_pti);
   assign ip_vpi = VPI_W'(IP_VPI_BASE) + VPI_W'(route_vp);

   always_comb begin
      fwd        = 1'b0;
      nxt_vpi    = rd_vpi;
      nxt_vci    = rd_vci;
      upd_en     = 1'b0;
      upd_active = rd_active;
      upd_drop   = rd_drop;
      upd_vp     = rd_vp;
      upd_vpi    = rd_vpi;
      upd_vci    = rd_vci;
      take_vc    = 1'b0;
      give_vc    = 1'b0;
      if (in_valid) begin
         unique case (rd_kind)
            CK_NATIVE: fwd = 1'b1;
            CK_IP: begin
               if (user) begin
                  if (rd_active) begin
                     fwd = 1'b1;
                     if (eop) begin
                        upd_en     = 1'b1;
                        upd_active = 1'b0;
                        give_vc    = 1'b1;
                     end
                  end else if (rd_drop) begin
                     if (eop) begin
                        upd_en   = 1'b1;
                        upd_drop = 1'b0;
                     end
                  end else if (!fl_empty[route_vp]) begin
                     fwd     = 1'b1;
                     nxt_vpi = ip_vpi;
                     nxt_vci = fl_head[route_vp];
                     if (!eop) begin
                        take_vc    = 1'b1;
                        upd_en     = 1'b1;
                        upd_active = 1'b1;
                        upd_vp     = route_vp;
                        upd_vpi    = ip_vpi;
                        upd_vci    = fl_head[route_vp];
                     end
                  end else if (!eop) begin
                     upd_en   = 1'b1;
                     upd_drop = 1'b1;
                  end
               end
            end
            default: fwd = 1'b0;
         endcase
      end
   end

   // ---------------- output register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vpi   <= '0;
         out_vci   <= '0;
         out_pti   <= '0;
         out_pay   <= '0;
      end else begin
         out_valid <= fwd;
         if (fwd) begin
            out_vpi <= nxt_vpi;
            out_vci <= nxt_vci;
            out_pti <= in_pti;
            out_pay <= in_pay;
         end
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R10
   AST_NATIVE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rd_kind == CK_NATIVE) |=> (out_valid && out_vpi == $past(rd_vpi))); // R2
   AST_UNKNOWN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rd_kind == CK_NONE) |=> !out_valid); // R3
   AST_OPEN_KEEPS_VC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rd_kind == CK_IP && rd_active && user) |=>
      (out_valid && out_vci == $past(rd_vci))); // R5
   AST_CTRL_CELL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rd_kind == CK_IP && !user) |=> !out_valid); // R9

   logic unused_pay;
   assign unused_pay = ^{PAY_W{1'b0}};

endmodule

// File: tb/test_wipf_cell_filter.sv
module test_wipf_cell_filter;

   localparam int VPI_W = 8, VCI_W = 16, PB = 24, DB = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [VPI_W-1:0]  in_vpi = '0;
   logic [VCI_W-1:0]  in_vci = '0;
   logic [2:0]        in_pti = '0;
   logic [8*PB-1:0]   in_pay = '0;
   logic              cfg_conn_we = 1'b0;
   logic [5:0]        cfg_conn_idx = '0;
   logic [1:0]        cfg_conn_kind = '0;
   logic [VPI_W-1:0]  cfg_conn_vpi = '0;
   logic [VCI_W-1:0]  cfg_conn_vci = '0;
   logic              cfg_route_we = 1'b0;
   logic [7:0]        cfg_route_key = '0;
   logic [1:0]        cfg_route_vp = '0;
   logic              out_valid;
   logic [VPI_W-1:0]  out_vpi;
   logic [VCI_W-1:0]  out_vci;
   logic [2:0]        out_pti;
   logic [8*PB-1:0]   out_pay;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wipf_cell_filter #(
      .FL_DEPTH (4), .VC_BASE (100), .IP_VPI_BASE (40),
      .PAY_BYTES (PB), .DST_BYTE (DB)
   ) i_wipf_cell_filter (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_vpi (in_vpi), .in_vci (in_vci),
      .in_pti (in_pti), .in_pay (in_pay),
      .cfg_conn_we (cfg_conn_we), .cfg_conn_idx (cfg_conn_idx),
      .cfg_conn_kind (cfg_conn_kind), .cfg_conn_vpi (cfg_conn_vpi),
      .cfg_conn_vci (cfg_conn_vci),
      .cfg_route_we (cfg_route_we), .cfg_route_key (cfg_route_key),
      .cfg_route_vp (cfg_route_vp),
      .out_valid (out_valid), .out_vpi (out_vpi), .out_vci (out_vci),
      .out_pti (out_pti), .out_pay (out_pay)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_conn(input int vpi, input int vci, input int kind, input int ovpi, input int ovci);
      @(negedge clk);
      cfg_conn_we   = 1'b1;
      cfg_conn_idx  = {vpi[1:0], vci[3:0]};
      cfg_conn_kind = kind[1:0];
      cfg_conn_vpi  = ovpi[7:0];
      cfg_conn_vci  = ovci[15:0];
      @(negedge clk);
      cfg_conn_we   = 1'b0;
   endtask

   task automatic cfg_route(input int key, input int vp);
      @(negedge clk);
      cfg_route_we  = 1'b1;
      cfg_route_key = key[7:0];
      cfg_route_vp  = vp[1:0];
      @(negedge clk);
      cfg_route_we  = 1'b0;
   endtask

   // present one cell, then check the registered output one clock later
   task automatic send(input string req, input int vpi, input int vci, input int pti,
                       input int dst, input bit exp_v, input int exp_vpi, input int exp_vci);
      logic [8*PB-1:0] pay;
      pay = '0;
      pay[7:0] = 8'hA5 ^ 8'(vci);
      pay[8*DB +: 8] = dst[7:0];
      @(negedge clk);
      in_valid = 1'b1;
      in_vpi   = vpi[7:0];
      in_vci   = vci[15:0];
      in_pti   = pti[2:0];
      in_pay   = pay;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, 64'(out_valid), 64'(exp_v));
      if (exp_v) begin
         check({req, " vpi"}, 64'(out_vpi), 64'(exp_vpi));
         check({req, " vci"}, 64'(out_vci), 64'(exp_vci));
         check({req, " pti"}, 64'(out_pti), 64'(pti));
         check({req, " pay"}, 64'(out_pay[63:0]), 64'(pay[63:0]));
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 out_valid after reset", 64'(out_valid), 64'd0);
      send("R3 unconfigured entry", 0, 3, 0, 0, 1'b0, 0, 0);
      @(negedge clk);
      check("R10 idle cycle", 64'(out_valid), 64'd0);
   endtask

   task automatic t_native;
      cfg_conn(1, 5, 1, 7, 300);
      send("R2 native translate", 1, 5, 0, 9, 1'b1, 7, 300);
      send("R2 native eop", 1, 5, 1, 9, 1'b1, 7, 300);
   endtask

   task automatic t_packets;
      cfg_route(10, 1);
      cfg_conn(2, 1, 2, 0, 0);
      send("R4 first cell", 2, 1, 0, 10, 1'b1, 41, 100);
      send("R5 middle cell", 2, 1, 0, 99, 1'b1, 41, 100);
      send("R6 last cell", 2, 1, 1, 99, 1'b1, 41, 100);
      send("R6 next packet first", 2, 1, 0, 10, 1'b1, 41, 101);
      send("R6 next packet last", 2, 1, 1, 0, 1'b1, 41, 101);
   endtask

   task automatic t_single;
      cfg_route(20, 2);
      cfg_conn(2, 2, 2, 0, 0);
      send("R7 single-cell packet", 2, 2, 1, 20, 1'b1, 42, 100);
      send("R7 VC not consumed", 2, 2, 1, 20, 1'b1, 42, 100);
      send("R1 FIFO order first", 2, 2, 0, 20, 1'b1, 42, 100);
      send("R6 close", 2, 2, 1, 20, 1'b1, 42, 100);
   endtask

   task automatic t_exhaust;
      cfg_route(30, 3);
      for (int c = 0; c < 5; c++) cfg_conn(3, c, 2, 0, 0);
      for (int c = 0; c < 4; c++)
         send("R1 drain VP3 in order", 3, c, 0, 30, 1'b1, 43, 100 + c);
      send("R8 empty list first dropped", 3, 4, 0, 30, 1'b0, 0, 0);
      send("R8 middle dropped", 3, 4, 0, 30, 1'b0, 0, 0);
      send("R9 control cell dropped", 3, 1, 4, 30, 1'b0, 0, 0);
      send("R9 state unchanged", 3, 1, 0, 30, 1'b1, 43, 101);
      send("R8 last dropped", 3, 4, 1, 30, 1'b0, 0, 0);
      send("R6 release VC", 3, 0, 1, 30, 1'b1, 43, 100);
      send("R8 retry gets returned VC", 3, 4, 0, 30, 1'b1, 43, 100);
      send("R5 retried packet middle", 3, 4, 0, 30, 1'b1, 43, 100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_native();
      t_packets();
      t_single();
      t_exhaust();
      @(negedge clk);
      check("R10 quiet at end", 64'(out_valid), 64'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule